// File: doc/BRIEF.md
# Staggered Multi-Channel PWM Converter

This block is a bank of pulse-width modulators. Each one drives a slow analogue control voltage through an external RC filter. Every channel owns a duty register that is loaded through a plain register-write port. All channels compare against one shared free-running period counter. That counter advances only on cycles where the PWM clock enable is high, so one period is 2^CNT_W enabled cycles (256 by default). Each output models an open-drain pin through an active-low pull-down enable: a 0 pulls the pin low, and a 1 releases it so the external pull-up can raise it.

The channels are not aligned to a common counter zero. Channel n runs on its own phase, which is the shared count minus n times the stagger step. Its rising edge therefore falls one enabled cycle after the rising edge of channel n-1. This spreads the switching current across the period. The duty value is the number of released cycles in each period, so the range runs from 0 to 255/256.

A written duty value first goes to a holding register. A channel's compare register picks it up only when that channel's own phase restarts at zero, so a period that has already started is never cut short or stretched.

Top module: `stagger_pwm_bank`

## Requirements
- R1: After reset every duty and compare register holds 0 and every `pull_n` bit is 0 (pin pulled low).
- R2: Channel n's `pull_n` bit is 1 in the clock after a state where ((count − n) mod 256) < its compare value, and 0 otherwise. With the enable high every cycle, any 256 consecutive cycles show exactly `duty` released cycles.
- R3: With nonzero duties and the enable high every cycle, the rising edge of channel n comes exactly one cycle after the rising edge of channel n−1 (mod 256), with channel 0 first.
- R4: A duty of 0 keeps the pin pulled low for the whole period. A duty of 255 pulls it low for exactly one enabled cycle per period.
- R5: A write with `wr_addr` = n (0 ≤ n < 5) sets the duty of channel n. A write to an address from 5 to 7 changes no channel.
- R6: A new duty takes effect only at the start of the next period of its own channel. If the write lands on the same edge as that channel's reload, the old value runs for one more full period.
- R7: The shared counter advances by one, modulo 256, only on cycles with `pwm_tick` high. While `pwm_tick` stays low, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | PWM clock enable; one counter step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Channel register address |
| wr_data | input | 8 | Duty value to write |
| pull_n | output | 5 | Per-pin active-low pull-down enable (0 = pull low, 1 = release) |

## Verification
Two functions can fall in the same cycle: a duty write and the reload edge of the addressed channel. The bench provokes this by timing a write of channel 0 to its own model counter, so that the write lands on the edge where the count wraps from 255. It then counts released cycles over the next two full periods and expects the old duty first and the new duty second. A cycle-by-cycle arithmetic model also follows the whole run, including gated and stalled enable patterns.

// File: rtl/stagger_pwm_pkg.sv
package stagger_pwm_pkg;

   // Output timing variant of a lane: compare result straight out, or one flop deep.
   typedef enum logic {
      PWM_OUT_COMB = 1'b0,
      PWM_OUT_FLOP = 1'b1
   } pwm_out_style_e;

   localparam int unsigned PWM_DEF_CHANNELS = 5;
   localparam int unsigned PWM_DEF_CNT_W    = 8;
   localparam int unsigned PWM_DEF_ADDR_W   = 3;

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (tick) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count = count_q;

endmodule

// File: rtl/pwm_duty_file.sv
module pwm_duty_file #(
   parameter int unsigned NUM_CH    = 5,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned BASE_ADDR = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [CNT_W-1:0]             wr_data,
   output logic [NUM_CH-1:0][CNT_W-1:0] hold
);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + g);
      logic [CNT_W-1:0] hold_q;
      logic             hit;

      assign hit = wr_en && (wr_addr == SLOT_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (hit) begin
            hold_q <= wr_data;
         end
      end

      assign hold[g] = hold_q;
   end

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
   import stagger_pwm_pkg::*;
#(
   parameter int unsigned    CNT_W     = 8,
   parameter int unsigned    OFFS      = 0,
   parameter pwm_out_style_e OUT_STYLE = PWM_OUT_FLOP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] hold,
   output logic [CNT_W-1:0] active,
   output logic             pin_rel
);

   localparam logic [CNT_W-1:0] OFFS_V = CNT_W'(OFFS);

   logic [CNT_W-1:0] phase;
   logic [CNT_W-1:0] active_q;
   logic             reload;
   logic             high_w;

   // Lane-local phase; the reload lands on the edge where it rolls back to zero.
   assign phase  = count - OFFS_V;
   assign reload = tick && (phase == '1);
   assign high_w = phase < active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
      end else if (reload) begin
         active_q <= hold;
      end
   end

   assign active = active_q;

   if (OUT_STYLE == PWM_OUT_FLOP) begin : g_flop
      logic rel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rel_q <= 1'b0;
         end else begin
            rel_q <= high_w;
         end
      end
      assign pin_rel = rel_q;
   end else begin : g_comb
      assign pin_rel = high_w;
   end

endmodule

// File: rtl/stagger_pwm_bank.sv
module stagger_pwm_bank
   import stagger_pwm_pkg::*;
#(
   parameter int unsigned    NUM_CH    = PWM_DEF_CHANNELS,
   parameter int unsigned    CNT_W     = PWM_DEF_CNT_W,
   parameter int unsigned    ADDR_W    = PWM_DEF_ADDR_W,
   parameter int unsigned    BASE_ADDR = 0,
   parameter int unsigned    STAGGER   = 1,
   parameter pwm_out_style_e OUT_STYLE = PWM_OUT_FLOP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] pull_n
);

   localparam int unsigned PERIOD = 2 ** CNT_W;
   localparam int unsigned SPAN   = (NUM_CH - 1) * STAGGER;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("stagger_pwm_bank: NUM_CH must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("stagger_pwm_bank: CNT_W must be within 2..16");
   end
   if (SPAN >= PERIOD) begin : g_bad_span
      $error("stagger_pwm_bank: stagger span must stay inside one period");
   end
   if (BASE_ADDR + NUM_CH > 2 ** ADDR_W) begin : g_bad_addr
      $error("stagger_pwm_bank: channel addresses exceed the address space");
   end

   logic [CNT_W-1:0]             cnt_w;
   logic [NUM_CH-1:0][CNT_W-1:0] hold_w;
   logic [NUM_CH-1:0][CNT_W-1:0] act_w;

   pwm_period_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (pwm_tick),
      .count (cnt_w)
   );

   pwm_duty_file #(
      .NUM_CH    (NUM_CH),
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) duty_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hold    (hold_w)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      pwm_lane #(
         .CNT_W     (CNT_W),
         .OFFS      (g * STAGGER),
         .OUT_STYLE (OUT_STYLE)
      ) lane_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (pwm_tick),
         .count   (cnt_w),
         .hold    (hold_w[g]),
         .active  (act_w[g]),
         .pin_rel (pull_n[g])
      );
   end

endmodule

// File: rtl/stagger_pwm_bank_chk.sv
module stagger_pwm_bank_chk
   import stagger_pwm_pkg::*;
#(
   parameter int unsigned    NUM_CH    = 5,
   parameter int unsigned    CNT_W     = 8,
   parameter int unsigned    STAGGER   = 1,
   parameter pwm_out_style_e OUT_STYLE = PWM_OUT_FLOP
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         pwm_tick,
   input logic [NUM_CH-1:0]            pull_n,
   input logic [CNT_W-1:0]             cnt_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_q
);

   AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pull_n == '0)); // R1

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_tick |=> $stable(cnt_q)); // R7

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R7

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [CNT_W-1:0] OFFS_V = CNT_W'(g * STAGGER);

      AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (act_q[g] != $past(act_q[g])) |-> (cnt_q == OFFS_V)); // R6

      AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         ((act_q[g] == '0) && ($past(act_q[g]) == '0)) |-> !pull_n[g]); // R4

      if (OUT_STYLE == PWM_OUT_FLOP) begin : g_flop
         AST_RISE_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pull_n[g]) |-> ($past(cnt_q) == OFFS_V)); // R3
      end else begin : g_comb
         AST_RISE_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pull_n[g]) |-> (cnt_q == OFFS_V)); // R3
      end
   end

endmodule

bind stagger_pwm_bank stagger_pwm_bank_chk #(
   .NUM_CH    (NUM_CH),
   .CNT_W     (CNT_W),
   .STAGGER   (STAGGER),
   .OUT_STYLE (OUT_STYLE)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_tick (pwm_tick),
   .pull_n   (pull_n),
   .cnt_q    (cnt_w),
   .act_q    (act_w)
);

// File: tb/stagger_pwm_bank_tb_top.sv
module stagger_pwm_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_tick = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [4:0] pull_n;

   int    checks = 0;
   int    errors = 0;
   bit    chk_on = 1'b0;
   string cur_tag = "R2";

   // bench model state
   int         m_cnt = 0;
   int         m_hold [NCH];
   int         m_act  [NCH];
   logic [4:0] m_exp = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   stagger_pwm_bank dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_tick (pwm_tick),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pull_n   (pull_n)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0;
         m_exp = '0;
         for (int i = 0; i < NCH; i++) begin
            m_hold[i] = 0;
            m_act[i]  = 0;
         end
      end else begin
         for (int i = 0; i < NCH; i++) begin
            int ph;
            ph = (m_cnt - i + 256) % 256;
            m_exp[i] = (ph < m_act[i]);
            if (pwm_tick && ph == 255) m_act[i] = m_hold[i];
         end
         if (wr_en && wr_addr < 3'd5) m_hold[wr_addr] = int'(wr_data);
         if (pwm_tick) m_cnt = (m_cnt + 1) % 256;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the arithmetic model
   always @(negedge clk) begin
      if (chk_on) check(pull_n === m_exp, cur_tag, int'(pull_n), int'(m_exp));
   end

   task automatic write_reg(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(addr);
      wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input int d [NCH], input string tag, input bit chk_rise);
      int         hi [NCH];
      int         rise [NCH];
      logic [4:0] prev;
      for (int i = 0; i < NCH; i++) begin
         hi[i] = 0;
         rise[i] = -1;
      end
      @(negedge clk);
      prev = pull_n;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         for (int i = 0; i < NCH; i++) begin
            if (pull_n[i]) hi[i]++;
            if (pull_n[i] && !prev[i]) rise[i] = k;
         end
         prev = pull_n;
      end
      for (int i = 0; i < NCH; i++) check(hi[i] == d[i], tag, hi[i], d[i]);
      if (chk_rise) begin
         for (int i = 1; i < NCH; i++) begin
            int gap;
            gap = (rise[i] - rise[i-1] + 256) % 256;
            check(rise[i] >= 0 && rise[i-1] >= 0 && gap == 1, "R3 stagger gap", gap, 1);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int         d1 [NCH] = '{0, 1, 128, 254, 255};
      int         d2 [NCH] = '{10, 20, 30, 40, 50};
      int         d3 [NCH] = '{10, 20, 200, 40, 50};
      int         d4 [NCH] = '{99, 20, 200, 40, 50};
      int         cnt_hi;
      logic [4:0] snap;

      repeat (5) @(negedge clk);
      check(pull_n === 5'b0, "R1 during reset", int'(pull_n), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pull_n === 5'b0, "R1 after reset", int'(pull_n), 0);
      chk_on = 1'b1;
      cur_tag = "R1";
      idle(300);
      check(pull_n === 5'b0, "R1 duty zero after reset", int'(pull_n), 0);

      // boundary duties: 0, 1, mid, 254, 255
      cur_tag = "R4";
      for (int i = 0; i < NCH; i++) write_reg(i, d1[i]);
      idle(600);
      measure(d1, "R4 boundary duty", 1'b0);

      // ordinary duties plus stagger
      cur_tag = "R2";
      for (int i = 0; i < NCH; i++) write_reg(i, d2[i]);
      idle(600);
      measure(d2, "R2 duty count", 1'b1);

      // unused addresses leave every channel untouched
      cur_tag = "R5";
      write_reg(5, 8'hAB);
      write_reg(6, 8'hFF);
      write_reg(7, 8'h01);
      idle(600);
      measure(d2, "R5 unused address", 1'b1);

      // mid-period write of channel 2
      cur_tag = "R6";
      idle(77);
      write_reg(2, 200);
      idle(600);
      measure(d3, "R6 mid-period write", 1'b0);

      // write coinciding with channel 0 reload
      while (m_cnt != 255) @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 3'd0;
      wr_data = 8'd99;
      @(negedge clk);
      wr_en = 1'b0;
      cnt_hi = 0;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         if (pull_n[0]) cnt_hi++;
      end
      check(cnt_hi == 10, "R6 old duty runs one more period", cnt_hi, 10);
      cnt_hi = 0;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         if (pull_n[0]) cnt_hi++;
      end
      check(cnt_hi == 99, "R6 new duty next period", cnt_hi, 99);
      measure(d4, "R6 settled", 1'b1);

      // stalled enable: outputs hold
      cur_tag = "R7";
      @(negedge clk);
      pwm_tick = 1'b0;
      idle(2);
      snap = pull_n;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         check(pull_n === snap, "R7 stalled hold", int'(pull_n), int'(snap));
      end

      // gated enable, one tick in three, with a write in flight
      for (int k = 0; k < 1800; k++) begin
         @(negedge clk);
         pwm_tick = (k % 3 == 0);
         if (k == 400) begin
            wr_en = 1'b1;
            wr_addr = 3'd4;
            wr_data = 8'd255;
         end else begin
            wr_en = 1'b0;
         end
      end
      @(negedge clk);
      pwm_tick = 1'b1;
      idle(600);
      d4[4] = 255;
      measure(d4, "R7 gated run settled", 1'b0);

      chk_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule